// File: doc/BRIEF.md
# I2C Slave Front End with Bit-Clock Gating

This block is the bus-facing half of a small peripheral on a two-wire I2C bus with 7-bit addressing. It samples the SCL and SDA lines on a much faster system clock, finds START, repeated START and STOP conditions, and shifts in the address byte. Each address bit is compared with the device address as soon as it arrives. The upper six bits of the device address are a build-time constant and the lowest bit comes from a select pin. A matching address is acknowledged. The first bit that differs sends the block into a parked state, where SCL edges no longer reach the bit logic until the next START.

In a write transfer, every received byte is handed to a command layer with a one-cycle strobe and then acknowledged. In a read transfer, the bus turns around after the address acknowledge. The block fetches a byte from the command layer, shifts it out MSB first by pulling SDA low through an open-drain enable, and samples the master's acknowledge. It keeps sending while the master acknowledges and lets go of the bus on a not-acknowledge. The command layer also gets framing strobes: start, stop, abort, and the end of every ninth clock. It should commit a byte only on that ninth-clock strobe, so a transfer cut short never updates its registers.

Top module: `i2cs_front`

## Requirements
- R1: While reset is high and in the first cycle after it, `sda_oe` and every strobe output (`rx_valid`, `ack_phase`, `start_flag`, `stop_flag`, `abort_flag`, `tx_load`) are 0.
- R2: A START (SDA falling while SCL is high) gives exactly one `start_flag` pulse. The strobes `start_flag`, `stop_flag`, `rx_valid` and `ack_phase` never pulse in the same cycle.
- R3: The address byte is sent MSB first as seven address bits and then R/W (0 = write, 1 = read). The device address is `{ADDR_HI, addr_sel}`, with `ADDR_HI` defaulting to 6'b011100. On a match, the block pulls SDA low for the whole ninth clock.
- R4: When an address bit differs from the device address, the block gives no acknowledge. All later bytes are then ignored (no `rx_valid`, no SDA drive, no `stop_flag`) until the next START.
- R5: The all-zero general call address is never acknowledged.
- R6: After each written data byte, the block pulses `rx_valid` with the byte on `rx_data` and drives the acknowledge. `ack_phase` pulses at the SCL fall that ends the ninth clock. `rx_data` changes only when `rx_valid` pulses.
- R7: In a read transfer, `tx_load` pulses as `tx_data` is latched: at the end of the address acknowledge and at the end of each master acknowledge. The byte is driven MSB first. After a master not-acknowledge, SDA is released and no further byte is loaded.
- R8: A STOP inside the same SCL high phase as the START before it is ignored. No `stop_flag` pulses, and the transfer goes on.
- R9: A STOP at any bit position ends an addressed transfer with a `stop_flag` pulse and releases SDA. If two or more bits of the current byte have already been clocked in, `abort_flag` pulses with it and no `rx_valid` follows.
- R10: A repeated START begins a new address phase, and write transfers back to back with or without a STOP between them are all accepted.
- R11: The block changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| addr_sel | input | 1 | Lowest bit of the device address |
| tx_data | input | 8 | Next read byte from the command layer |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new written byte |
| rx_data | output | 8 | Last received write byte |
| ack_phase | output | 1 | One-cycle strobe at the SCL fall ending a ninth clock |
| tx_load | output | 1 | One-cycle strobe: `tx_data` was latched for sending |
| start_flag | output | 1 | One-cycle strobe on a START or repeated START |
| stop_flag | output | 1 | One-cycle strobe on a STOP ending an addressed transfer |
| abort_flag | output | 1 | One-cycle strobe: the transfer ended inside a byte |

## Verification
The bound checker checks four things on every cycle. SDA drive changes happen only while SCL is low. The strobes are mutually exclusive. SDA is released whenever a START or STOP is reported. `rx_data` stays unchanged between strobes, each received byte is acknowledged, and every load and abort coincides with its framing strobe. Only bus scenarios can show the rest. That covers whether the address compare accepts or rejects the right bytes, including the general call. It also covers the parked state after a mismatch, the read byte order and the not-acknowledge release. Finally, it covers ignoring a STOP in the START's own high phase, and abort reporting for a STOP in the middle of a byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_PARK,   // bit clock gated off, waiting for START
    ST_ADDR,   // shifting in address + R/W
    ST_AACK,   // driving address acknowledge
    ST_WDATA,  // shifting in a write byte
    ST_WACK,   // driving write acknowledge
    ST_RDATA,  // shifting out a read byte
    ST_RACK    // sampling master acknowledge
  } phase_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic prv
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b1;
        else     q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b1;
        else     q[i] <= q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prv <= 1'b1;
    else     prv <= q[STAGES-1];
  end

  assign lvl = q[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_lvl,
  input  logic scl_prv,
  input  logic sda_lvl,
  input  logic sda_prv,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_high2;
  logic stop_raw;
  logic same_high;  // set by a START until SCL next falls

  assign scl_high2 = scl_lvl & scl_prv;
  assign scl_rise  = scl_lvl & ~scl_prv;
  assign scl_fall  = ~scl_lvl & scl_prv;
  assign start_ev  = scl_high2 & sda_prv & ~sda_lvl;
  assign stop_raw  = scl_high2 & ~sda_prv & sda_lvl;
  assign stop_ev   = stop_raw & ~same_high;

  always_ff @(posedge clk) begin
    if (rst)           same_high <= 1'b0;
    else if (start_ev) same_high <= 1'b1;
    else if (scl_fall) same_high <= 1'b0;
  end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sda_oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              ack_phase,
  output logic              tx_load,
  output logic              start_flag,
  output logic              stop_flag,
  output logic              abort_flag
);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] PARTIAL = CNT_W'(2);

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  rx_sh;
  logic [BYTE_W-1:0]  tx_sh;
  logic               rw;
  logic               m_ack;
  logic               bit_en;
  logic               rise_g;
  logic               fall_g;
  logic               exp_bit;
  logic               gcall;
  logic               mid_byte;

  // gated bit clock: parked interface sees no SCL edges
  assign bit_en   = (phase != ST_PARK);
  assign rise_g   = scl_rise & bit_en;
  assign fall_g   = scl_fall & bit_en;
  assign exp_bit  = dev_addr[3'd6 - cnt[2:0]];
  assign gcall    = (cnt == CNT_W'(ADDR_W - 1)) && (rx_sh[ADDR_W-2:0] == '0) && !sda_lvl;
  assign mid_byte = bit_en && (cnt >= PARTIAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= ST_PARK;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rw         <= 1'b0;
      m_ack      <= 1'b0;
      sda_oe     <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      ack_phase  <= 1'b0;
      tx_load    <= 1'b0;
      start_flag <= 1'b0;
      stop_flag  <= 1'b0;
      abort_flag <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      ack_phase  <= 1'b0;
      tx_load    <= 1'b0;
      start_flag <= 1'b0;
      stop_flag  <= 1'b0;
      abort_flag <= 1'b0;
      if (start_ev) begin
        start_flag <= 1'b1;
        abort_flag <= mid_byte;
        phase      <= ST_ADDR;
        cnt        <= '0;
        sda_oe     <= 1'b0;
      end else if (stop_ev) begin
        stop_flag  <= bit_en;
        abort_flag <= mid_byte;
        phase      <= ST_PARK;
        cnt        <= '0;
        sda_oe     <= 1'b0;
      end else if (rise_g) begin
        unique case (phase)
          ST_ADDR: begin
            rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
            cnt   <= cnt + 1'b1;
            if (cnt < CNT_W'(ADDR_W)) begin
              if ((sda_lvl != exp_bit) || gcall) begin
                phase <= ST_PARK;
                cnt   <= '0;
              end
            end else begin
              rw <= sda_lvl;
            end
          end
          ST_WDATA: begin
            rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
            cnt   <= cnt + 1'b1;
          end
          ST_RDATA: cnt   <= cnt + 1'b1;
          ST_RACK:  m_ack <= !sda_lvl;
          default: ;
        endcase
      end else if (fall_g) begin
        unique case (phase)
          ST_ADDR: begin
            if (cnt == FULL) begin
              phase  <= ST_AACK;
              sda_oe <= 1'b1;
              cnt    <= '0;
            end
          end
          ST_AACK: begin
            ack_phase <= 1'b1;
            if (rw) begin
              phase   <= ST_RDATA;
              tx_sh   <= tx_data;
              sda_oe  <= !tx_data[BYTE_W-1];
              tx_load <= 1'b1;
            end else begin
              phase  <= ST_WDATA;
              sda_oe <= 1'b0;
            end
          end
          ST_WDATA: begin
            if (cnt == FULL) begin
              rx_valid <= 1'b1;
              rx_data  <= rx_sh;
              sda_oe   <= 1'b1;
              phase    <= ST_WACK;
              cnt      <= '0;
            end
          end
          ST_WACK: begin
            ack_phase <= 1'b1;
            sda_oe    <= 1'b0;
            phase     <= ST_WDATA;
          end
          ST_RDATA: begin
            if (cnt == FULL) begin
              sda_oe <= 1'b0;
              phase  <= ST_RACK;
              cnt    <= '0;
            end else begin
              tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe <= !tx_sh[BYTE_W-2];
            end
          end
          ST_RACK: begin
            ack_phase <= 1'b1;
            if (m_ack) begin
              phase   <= ST_RDATA;
              tx_sh   <= tx_data;
              sda_oe  <= !tx_data[BYTE_W-1];
              tx_load <= 1'b1;
            end else begin
              phase <= ST_PARK;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_front.sv
module i2cs_front
  import i2cs_pkg::*;
#(
  parameter logic [ADDR_W-2:0] ADDR_HI     = 6'b011100,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sda_oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              ack_phase,
  output logic              tx_load,
  output logic              start_flag,
  output logic              stop_flag,
  output logic              abort_flag
);
  logic scl_lvl, scl_prv, sda_lvl, sda_prv;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic [ADDR_W-1:0] dev_addr;

  assign dev_addr = {ADDR_HI, addr_sel};

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_i), .lvl(scl_lvl), .prv(scl_prv)
  );

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .din(sda_i), .lvl(sda_lvl), .prv(sda_prv)
  );

  i2cs_cond u_cond (
    .clk(clk), .rst(rst),
    .scl_lvl(scl_lvl), .scl_prv(scl_prv),
    .sda_lvl(sda_lvl), .sda_prv(sda_prv),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cs_engine u_engine (
    .clk(clk), .rst(rst), .dev_addr(dev_addr), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .tx_data(tx_data),
    .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
    .ack_phase(ack_phase), .tx_load(tx_load),
    .start_flag(start_flag), .stop_flag(stop_flag), .abort_flag(abort_flag)
  );
endmodule

// File: rtl/i2cs_front_chk.sv
module i2cs_front_chk
  import i2cs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_lvl,
  input logic              sda_oe,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_data,
  input logic              ack_phase,
  input logic              tx_load,
  input logic              start_flag,
  input logic              stop_flag,
  input logic              abort_flag
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_lvl); // R11
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_flag, stop_flag, rx_valid, ack_phase})); // R2
  AST_BYTE_ACKED: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> sda_oe); // R6
  AST_RXDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> rx_valid); // R6
  AST_START_FREE: assert property (@(posedge clk) disable iff (rst)
    start_flag |-> !sda_oe); // R10
  AST_STOP_FREE: assert property (@(posedge clk) disable iff (rst)
    stop_flag |-> !sda_oe); // R9
  AST_ABORT_FRAMED: assert property (@(posedge clk) disable iff (rst)
    abort_flag |-> (start_flag || stop_flag)); // R9
  AST_LOAD_AT_ACK: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> ack_phase); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !(sda_oe || rx_valid || ack_phase || tx_load || start_flag || stop_flag || abort_flag)); // R1
endmodule

bind i2cs_front i2cs_front_chk u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
  .rx_valid(rx_valid), .rx_data(rx_data), .ack_phase(ack_phase),
  .tx_load(tx_load), .start_flag(start_flag), .stop_flag(stop_flag),
  .abort_flag(abort_flag)
);

// File: tb/tb_i2cs_front.sv
module tb_i2cs_front;
  localparam int Q = 10;  // system clocks per quarter SCL period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sda_bus;
  logic sda_oe, rx_valid, ack_phase, tx_load, start_flag, stop_flag, abort_flag;
  logic [7:0] rx_data;

  int n_cmp = 0, n_bad = 0;
  int n_start = 0, n_stop = 0, n_abort = 0, n_rx = 0, n_ackp = 0, n_tx = 0;
  logic [7:0] last_rx = 8'h00;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  assign sda_bus = sda_m & ~sda_oe;

  i2cs_front dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .addr_sel(addr_sel),
    .tx_data(tx_data), .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
    .ack_phase(ack_phase), .tx_load(tx_load), .start_flag(start_flag),
    .stop_flag(stop_flag), .abort_flag(abort_flag)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (start_flag) n_start <= n_start + 1;
      if (stop_flag)  n_stop  <= n_stop + 1;
      if (abort_flag) n_abort <= n_abort + 1;
      if (ack_phase)  n_ackp  <= n_ackp + 1;
      if (tx_load)    n_tx    <= n_tx + 1;
      if (rx_valid) begin
        n_rx    <= n_rx + 1;
        last_rx <= rx_data;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); b = sda_bus; qw(); scl = 1'b0; qw();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!give_ack);
  endtask

  // {address byte, data byte, expect acknowledge}; device address 0x38 -> 0x70 write
  localparam int NV = 6;
  localparam logic [16:0] VEC [NV] = '{
    {8'h70, 8'hA5, 1'b1},
    {8'h70, 8'h00, 1'b1},
    {8'h70, 8'hFF, 1'b1},
    {8'h72, 8'h3C, 1'b0},  // A0 differs
    {8'h00, 8'h55, 1'b0},  // general call
    {8'hF0, 8'h12, 1'b0}   // first bit differs
  };

  initial begin : main
    logic ack;
    logic [7:0] d0, d1;
    int s_rx, s_stop, s_start, s_ackp, s_tx, s_abort;

    repeat (5) @(negedge clk);
    check("R1 oe in reset", sda_oe, 0);
    check("R1 strobes in reset", {rx_valid, ack_phase, tx_load, start_flag, stop_flag, abort_flag}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe after reset", sda_oe, 0);
    check("R1 strobes after reset", {rx_valid, ack_phase, tx_load, start_flag, stop_flag, abort_flag}, 0);
    qw();

    // table-driven single-byte writes
    for (int v = 0; v < NV; v++) begin
      s_rx = n_rx; s_stop = n_stop; s_start = n_start;
      bus_start();
      check("R2 start flag", n_start, s_start + 1);
      put_byte(VEC[v][16:9], ack);
      check(VEC[v][0] ? "R3 address ack" : "R4 R5 address nack", ack, VEC[v][0]);
      put_byte(VEC[v][8:1], ack);
      check(VEC[v][0] ? "R6 data ack" : "R4 data ignored", ack, VEC[v][0]);
      check("R6 R4 byte count", n_rx, s_rx + (VEC[v][0] ? 1 : 0));
      if (VEC[v][0]) check("R6 byte value", last_rx, VEC[v][8:1]);
      bus_stop();
      check("R9 R4 stop flag", n_stop, s_stop + (VEC[v][0] ? 1 : 0));
      qw();
    end

    // select pin changes the address LSB
    addr_sel = 1'b1;
    bus_start(); put_byte(8'h72, ack); check("R3 sel=1 addr 0x39 ack", ack, 1); bus_stop(); qw();
    bus_start(); put_byte(8'h70, ack); check("R4 sel=1 addr 0x38 nack", ack, 0); bus_stop(); qw();
    addr_sel = 1'b0;

    // several bytes in one write
    s_rx = n_rx; s_ackp = n_ackp;
    bus_start(); put_byte(8'h70, ack);
    put_byte(8'h11, ack); check("R6 first of burst ack", ack, 1);
    put_byte(8'h22, ack); check("R6 second of burst ack", ack, 1);
    check("R6 burst count", n_rx, s_rx + 2);
    check("R6 burst last", last_rx, 8'h22);
    check("R6 ninth-clock strobes", n_ackp, s_ackp + 3);
    bus_stop(); qw();

    // repeated START between writes
    s_start = n_start; s_stop = n_stop; s_rx = n_rx;
    bus_start(); put_byte(8'h70, ack); put_byte(8'h33, ack);
    bus_start(); put_byte(8'h70, ack); check("R10 addr after Sr ack", ack, 1);
    put_byte(8'h44, ack); check("R10 data after Sr ack", ack, 1);
    check("R10 last byte", last_rx, 8'h44);
    check("R10 two bytes", n_rx, s_rx + 2);
    check("R10 start count", n_start, s_start + 2);
    bus_stop();
    check("R10 one stop", n_stop, s_stop + 1);
    qw();

    // read transfer
    s_tx = n_tx; s_stop = n_stop;
    tx_data = 8'h96;
    bus_start(); put_byte(8'h71, ack); check("R7 read addr ack", ack, 1);
    tx_data = 8'h3B;
    get_byte(d0, 1'b1);
    check("R7 first read byte", d0, 8'h96);
    tx_data = 8'hC4;
    get_byte(d1, 1'b0);
    check("R7 second read byte", d1, 8'h3B);
    check("R7 loads", n_tx, s_tx + 2);
    qw();
    check("R7 released after nack", sda_oe, 0);
    get_bit(ack);
    check("R7 bus high after nack", ack, 1);
    check("R7 no load after nack", n_tx, s_tx + 2);
    bus_stop();
    check("R7 parked, no stop flag", n_stop, s_stop);
    qw();

    // STOP inside a byte
    s_stop = n_stop; s_abort = n_abort; s_rx = n_rx;
    bus_start(); put_byte(8'h70, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    check("R9 early stop flag", n_stop, s_stop + 1);
    check("R9 abort flag", n_abort, s_abort + 1);
    check("R9 no partial byte", n_rx, s_rx);
    check("R9 sda released", sda_oe, 0);
    qw();
    s_abort = n_abort;
    bus_start(); put_byte(8'h70, ack); check("R9 next transfer ack", ack, 1);
    put_byte(8'h0F, ack); bus_stop();
    check("R9 clean stop no abort", n_abort, s_abort);
    qw();

    // STOP in the same SCL high phase as START
    s_stop = n_stop; s_start = n_start;
    sda_m = 1'b0; qw(); sda_m = 1'b1; qw(); scl = 1'b0; qw();
    check("R8 start seen", n_start, s_start + 1);
    check("R8 stop ignored", n_stop, s_stop);
    put_byte(8'h70, ack); check("R8 transfer continues", ack, 1);
    put_byte(8'h5A, ack);
    check("R8 byte delivered", last_rx, 8'h5A);
    bus_stop();
    check("R8 real stop", n_stop, s_stop + 1);
    qw();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule